// File: doc/BRIEF.md
# Row Multiplex and Dimming Controller

This block scans a seven-row dot-matrix display of eight five-column characters. A multiplex clock enable advances a counter chain. An optional divide-by-16 prescaler can sit in front of that chain. The chain steps through the rows one at a time. For the active row, the 40 column bits read from the display memory are driven out, and exactly one row enable is asserted during the lit part of that row's slot.

Brightness is set only by the duty of each row strobe. Each row slot is split into sixteen equal counter ticks. The first fifteen ticks may be lit, and the last tick is always dark, so column data never changes while a row is on. A three-bit brightness code chooses how many of the fifteen ticks are lit. The top code turns every row off and serves as a power-down state. The code is taken into use only at a row boundary. A peak-current flag is registered straight through to the analog drivers.

The row index is also given as a read address for the display memory, which returns that row's column bits on `col_data` in the same cycle. A frame-start pulse marks the first output cycle of row 0 each time the scan wraps.

Top module: `row_mux_dimmer`

## Requirements
- R1: Rows are scanned in the order 0,1,...,6 and then wrap to 0. `row_en` is one-hot or all zero. `row_sel` gives the index of the current row slot.
- R2: A row slot lasts 16 counter ticks, numbered 0..15. `row_en` bit r is high, one cycle after the state, for ticks 0..N-1 of row r's slot. N is 15, 8, 6, 4, 3, 2, 1, 0 for brightness codes 0..7. Tick 15 is never lit.
- R3: Brightness code 7 keeps every row enable low for every slot that uses it.
- R4: `col_drive` equals `col_data` delayed by one clock. The brightness code has no effect on it.
- R5: With `prescale_div16`=1, the counter chain advances once per 16 `mux_en` pulses. With 0, it advances on every `mux_en` pulse, and the prescale count is held at zero.
- R6: `peak_sel` equals `peak_full` delayed by one clock (1 = full current, 0 = one eighth of full current).
- R7: A clock edge with `rst` high sets row 0, tick 0, brightness code 0 (full), and a cleared prescale count. In the next cycle every output register reads zero.
- R8: The brightness code is sampled only on the tick that ends a row slot. A code change inside a slot has no effect until the following slot.
- R9: `frame_start` is high for one cycle, in the first output cycle of a row-0 slot that was entered by a tick. It is never high just because reset was released.
- R10: `row_en` never changes directly from one nonzero value to a different nonzero value. At least one all-zero cycle separates two lit rows.
- R11: While `mux_en` is low, the counter chain holds its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_en | input | 1 | Multiplex clock enable, one pulse per multiplex tick |
| bright_code | input | 3 | Brightness code, 0 = full, 7 = off |
| peak_full | input | 1 | Peak current select from the control word |
| prescale_div16 | input | 1 | 1 = divide multiplex ticks by 16 |
| col_data | input | 40 | Column bits of the row given by `row_sel` |
| row_sel | output | 3 | Current row index, used as the memory read address |
| row_en | output | 7 | One-hot row strobe |
| col_drive | output | 40 | Registered column drive |
| peak_sel | output | 1 | Registered current select |
| frame_start | output | 1 | Pulse at the start of row 0 |

## Verification
The bench sweeps all eight brightness codes with `mux_en` held high. It counts the lit cycles of every row over one whole frame, which separates the duty table entries one from another. Sparse enable pulses show that the chain holds between ticks, and the divide-by-16 run shows that the prescaler stretches the slots rather than the duty. A run in which the brightness code changes every few cycles can only match the model if the code is latched at slot boundaries. Mid-run resets and peak-flag toggling check the cleared state and the one-cycle pass-through paths.

// File: rtl/rmd_pkg.sv
package rmd_pkg;
  localparam int SUB_SLOTS = 16;
  localparam int SUB_W     = $clog2(SUB_SLOTS);
  localparam int LVL_W     = 3;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [SUB_W-1:0] sub_t;

  localparam lvl_t LVL_OFF  = lvl_t'(7);
  localparam sub_t SUB_LAST = sub_t'(SUB_SLOTS - 1);

  // number of lit ticks per row slot for each brightness code
  function automatic sub_t on_slots(input lvl_t code);
    case (code)
      3'd0:    on_slots = sub_t'(15);
      3'd1:    on_slots = sub_t'(8);
      3'd2:    on_slots = sub_t'(6);
      3'd3:    on_slots = sub_t'(4);
      3'd4:    on_slots = sub_t'(3);
      3'd5:    on_slots = sub_t'(2);
      3'd6:    on_slots = sub_t'(1);
      default: on_slots = sub_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/rmd_prescaler.sv
module rmd_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mux_en,
  input  logic div_on,
  output logic tick
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !div_on) begin
      cnt_q <= '0;
    end else if (mux_en) begin
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CW'(1);
    end
  end

  assign tick = mux_en && (!div_on || (cnt_q == CNT_LAST));

  // R5: an advance needs a multiplex pulse
  a_r5_tick_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    tick |-> mux_en);

  // R5: in divide mode two advances are never back to back
  a_r5_div_spacing: assert property (@(posedge clk) disable iff (rst)
    (div_on && tick) |=> (!tick || !div_on));
endmodule

// File: rtl/rmd_scan_counter.sv
module rmd_scan_counter
  import rmd_pkg::*;
#(
  parameter int ROWS  = 7,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  lvl_t             code_in,
  output logic [ROW_W-1:0] row,
  output sub_t             sub,
  output lvl_t             lvl,
  output logic             advanced
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row      <= '0;
      sub      <= '0;
      lvl      <= '0;
      advanced <= 1'b0;
    end else begin
      advanced <= tick;
      if (tick) begin
        if (sub == SUB_LAST) begin
          sub <= '0;
          row <= (row == ROW_LAST) ? '0 : row + ROW_W'(1);
          lvl <= code_in;
        end else begin
          sub <= sub + sub_t'(1);
        end
      end
    end
  end

  // R1: row index stays inside the matrix
  a_r1_row_range: assert property (@(posedge clk) disable iff (rst)
    row <= ROW_LAST);

  // R1: a row change lands on tick 0 and either wraps or steps by one
  a_r1_row_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(row) |-> (sub == '0) && ((row == '0) || (row == $past(row) + ROW_W'(1))));

  // R8: the latched level only moves at a slot start
  a_r8_level_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl) |-> (sub == '0));
endmodule

// File: rtl/rmd_strobe_gen.sv
module rmd_strobe_gen
  import rmd_pkg::*;
#(
  parameter int ROWS  = 7,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] row,
  input  sub_t             sub,
  input  lvl_t             lvl,
  input  logic             advanced,
  input  logic [COL_W-1:0] col_in,
  input  logic             peak_in,
  output logic [ROWS-1:0]  row_en,
  output logic [COL_W-1:0] col_drive,
  output logic             peak_sel,
  output logic             frame_start
);
  logic            lit;
  logic [ROWS-1:0] row_d;

  assign lit = (sub < on_slots(lvl));

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_d[i] = lit && (row == ROW_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_en      <= '0;
      col_drive   <= '0;
      peak_sel    <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      row_en      <= row_d;
      col_drive   <= col_in;
      peak_sel    <= peak_in;
      frame_start <= advanced && (row == '0) && (sub == '0);
    end
  end

  // R1: at most one row strobe at a time
  a_r1_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_en));

  // R3: the off level drives no row
  a_r3_off_blanks: assert property (@(posedge clk) disable iff (rst)
    (lvl == LVL_OFF) |=> (row_en == '0));

  // R10: two lit rows never touch
  a_r10_guard_gap: assert property (@(posedge clk) disable iff (rst)
    ((row_en != '0) && ($past(row_en) != '0)) |-> (row_en == $past(row_en)));

  // R2: the last tick of a slot is dark in the following cycle
  a_r2_last_tick_dark: assert property (@(posedge clk) disable iff (rst)
    (sub == SUB_LAST) |=> (row_en == '0));
endmodule

// File: rtl/row_mux_dimmer.sv
module row_mux_dimmer
  import rmd_pkg::*;
#(
  parameter int ROWS    = 7,
  parameter int CHARS   = 8,
  parameter int COLS    = 5,
  parameter int PRE_DIV = 16,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = CHARS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mux_en,
  input  logic [2:0]       bright_code,
  input  logic             peak_full,
  input  logic             prescale_div16,
  input  logic [COL_W-1:0] col_data,
  output logic [ROW_W-1:0] row_sel,
  output logic [ROWS-1:0]  row_en,
  output logic [COL_W-1:0] col_drive,
  output logic             peak_sel,
  output logic             frame_start
);
  logic             tick;
  logic [ROW_W-1:0] row;
  sub_t             sub;
  lvl_t             lvl;
  logic             advanced;

  rmd_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .mux_en (mux_en),
    .div_on (prescale_div16),
    .tick   (tick)
  );

  rmd_scan_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .code_in  (bright_code),
    .row      (row),
    .sub      (sub),
    .lvl      (lvl),
    .advanced (advanced)
  );

  rmd_strobe_gen #(.ROWS(ROWS), .ROW_W(ROW_W), .COL_W(COL_W)) u_strobe (
    .clk         (clk),
    .rst         (rst),
    .row         (row),
    .sub         (sub),
    .lvl         (lvl),
    .advanced    (advanced),
    .col_in      (col_data),
    .peak_in     (peak_full),
    .row_en      (row_en),
    .col_drive   (col_drive),
    .peak_sel    (peak_sel),
    .frame_start (frame_start)
  );

  assign row_sel = row;

  // R6: current select follows the control bit one clock later
  a_r6_peak_follow: assert property (@(posedge clk) disable iff (rst)
    peak_full |=> peak_sel);

  // R9: a frame pulse only appears while row 0 is current
  a_r9_frame_row0: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row_sel == '0));
endmodule

// File: tb/row_mux_dimmer_tb_top.sv
`timescale 1ns/1ps
module row_mux_dimmer_tb_top;
  logic        clk = 1'b0;
  logic        rst, mux_en, peak_full, prescale_div16;
  logic [2:0]  bright_code;
  logic [39:0] col_data;
  logic [2:0]  row_sel;
  logic [6:0]  row_en;
  logic [39:0] col_drive;
  logic        peak_sel, frame_start;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [39:0] pat(input logic [2:0] r);
    return {8{5'(r * 7 + 3)}} ^ 40'h5A_C3_96_3C_A5;
  endfunction

  function automatic int exp_on(input int code);
    case (code)
      0: return 15; 1: return 8; 2: return 6; 3: return 4;
      4: return 3;  5: return 2; 6: return 1; default: return 0;
    endcase
  endfunction

  assign col_data = pat(row_sel);

  row_mux_dimmer dut_i (
    .clk(clk), .rst(rst), .mux_en(mux_en), .bright_code(bright_code),
    .peak_full(peak_full), .prescale_div16(prescale_div16), .col_data(col_data),
    .row_sel(row_sel), .row_en(row_en), .col_drive(col_drive),
    .peak_sel(peak_sel), .frame_start(frame_start)
  );

  // reference state derived from the requirements
  int m_row = 0, m_sub = 0, m_lvl = 0, m_p = 0;
  bit m_adv = 0;
  logic [6:0] prev_en = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input bit r, input bit en, input int c, input bit pk, input bit dv, input string tag);
    logic [6:0]  e_en;
    logic [39:0] e_col;
    bit e_pk, e_fs, tk;
    string t_en;
    rst = r; mux_en = en; bright_code = 3'(c); peak_full = pk; prescale_div16 = dv;
    t_en = tag;
    if (r) begin
      e_en = '0; e_col = '0; e_pk = 0; e_fs = 0; t_en = "R7";
    end else begin
      e_en  = (m_sub < exp_on(m_lvl)) ? 7'(1 << m_row) : 7'd0;
      if (m_lvl == 7) t_en = "R3";
      e_col = pat(3'(m_row));
      e_pk  = pk;
      e_fs  = m_adv && m_row == 0 && m_sub == 0;
    end
    tk = en && (!dv || m_p == 15);
    if (r) begin
      m_row = 0; m_sub = 0; m_lvl = 0; m_p = 0; m_adv = 0;
    end else begin
      m_p = dv ? (en ? (m_p + 1) % 16 : m_p) : 0;
      if (tk) begin
        if (m_sub == 15) begin
          m_sub = 0; m_row = (m_row == 6) ? 0 : m_row + 1; m_lvl = c;
        end else m_sub++;
      end
      m_adv = tk;
    end
    @(posedge clk);
    @(negedge clk);
    chk(row_en === e_en, t_en, 64'(row_en), 64'(e_en));
    chk(col_drive === e_col, r ? "R7" : "R4", 64'(col_drive), 64'(e_col));
    chk(peak_sel === e_pk, r ? "R7" : "R6", 64'(peak_sel), 64'(e_pk));
    chk(frame_start === e_fs, r ? "R7" : "R9", 64'(frame_start), 64'(e_fs));
    chk(row_sel === 3'(m_row), r ? "R7" : "R1", 64'(row_sel), 64'(m_row));
    chk(!(prev_en != 0 && row_en != 0 && prev_en != row_en), "R10", 64'(row_en), 64'(prev_en));
    prev_en = row_en;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int lit_cnt [7];
    step(1, 0, 0, 0, 0, "R7");
    step(1, 1, 3, 1, 1, "R7");
    // R2 / R3: sweep every brightness code, full-rate scan
    for (int code = 0; code < 8; code++) begin
      for (int k = 0; k < 128; k++) step(0, 1, code, code[0], 0, "R2");
      for (int r = 0; r < 7; r++) lit_cnt[r] = 0;
      for (int k = 0; k < 112; k++) begin
        step(0, 1, code, 1, 0, "R2");
        for (int r = 0; r < 7; r++) if (row_en[r]) lit_cnt[r]++;
      end
      for (int r = 0; r < 7; r++)
        chk(lit_cnt[r] == exp_on(code), code == 7 ? "R3 lit count" : "R2 lit count",
            64'(lit_cnt[r]), 64'(exp_on(code)));
    end
    // R11: sparse multiplex pulses
    for (int k = 0; k < 1500; k++) step(0, (k % 3) == 0, 1, 0, 0, "R11");
    // R5: divide-by-16 prescale, continuous and gappy pulses
    for (int k = 0; k < 2000; k++) step(0, 1, 2, 1, 1, "R5");
    for (int k = 0; k < 1000; k++) step(0, (k % 2) == 0, 0, 0, 1, "R5");
    // R7: reset in the middle of a run
    step(1, 1, 5, 1, 0, "R7");
    for (int k = 0; k < 200; k++) step(0, 1, 0, 1, 0, "R7");
    // R8 / R6: brightness and peak changing inside slots
    for (int k = 0; k < 2500; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(0, lfsr[0] | lfsr[1], int'(lfsr[6:4]), lfsr[9], k > 2000 ? lfsr[11] : 1'b0, "R8");
    end
    step(1, 0, 0, 0, 0, "R7");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule